// File: doc/BRIEF.md
# Segment Descriptor Address Translator

This block turns a 48-bit logical address into a 32-bit linear address. The upper 16 bits of the logical address are a selector and the lower 32 bits are an offset. The selector picks one 8-byte descriptor from either the global or the local descriptor table. The block fetches that descriptor over a simple memory read port, pulls the 32-bit segment base out of it, and adds the offset to the base.

Two table registers set where the tables are and how big they are. The global register comes out of reset covering a full 64 KB table at address zero. The local register comes out of reset empty. Either register can be loaded in any cycle.

Each request is checked before any memory traffic starts. A null global selector, or an entry that would run past the table length, returns a fault straight away and issues no read. Requests are handled one at a time. Each accepted request gets exactly one single-cycle response, which carries the linear address, a fault flag and the requested privilege level taken from the selector.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_rd_en` and `rsp_valid` are 0. The global table register holds base 0 and length 0xFFFF. The local table register holds base 0 and length 0.
- R2: Selector bits 15:3 are the entry index. Bit 2 picks the table (1 = local, 0 = global). Bits 1:0 are the requested privilege level, which is returned on `rsp_rpl` with the response.
- R3: For a request that does not fault, `mem_rd_en` is high for exactly one cycle, in the cycle after acceptance. `mem_addr` equals the chosen table base plus index×8, modulo 2^32. Only one read is issued per request.
- R4: The segment base is descriptor bits 63:56 followed by descriptor bits 39:16, giving a 32-bit value. `rsp_lin` equals that base plus the offset, modulo 2^32. The response appears in the cycle after `mem_rd_valid` is sampled.
- R5: When index×8+7 is greater than the chosen table's length, the response has `rsp_fault`=1 and `rsp_lin`=0, and no memory read is issued.
- R6: A selector with index 0 and bit 2 clear (the null selector) faults with no memory read. Index 0 in the local table is an ordinary entry.
- R7: `gtbl_ld` loads the global base and length, and `ltbl_ld` loads the local base and length. A load made in the same cycle that a request is accepted affects only later requests.
- R8: `req_ready` is high only while no request is in progress. `rsp_valid` lasts one cycle, and `req_ready` returns in the cycle after it. A faulting request responds in the cycle after acceptance.
- R9: With the reset table register in place, selector 0x18 reads global entry 3 at address 0x18 and reports privilege level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A translation request is presented |
| req_ready | output | 1 | The block can accept a request |
| req_sel | input | 16 | Selector half of the logical address |
| req_off | input | 32 | Offset half of the logical address |
| gtbl_ld | input | 1 | Load the global table register |
| gtbl_base | input | 32 | New global table base |
| gtbl_limit | input | 16 | New global table length (last valid byte) |
| ltbl_ld | input | 1 | Load the local table register |
| ltbl_base | input | 32 | New local table base |
| ltbl_limit | input | 16 | New local table length (last valid byte) |
| mem_rd_en | output | 1 | Descriptor read strobe |
| mem_addr | output | 32 | Descriptor read address |
| mem_rd_valid | input | 1 | Descriptor read data is valid |
| mem_rd_data | input | 64 | Descriptor read data |
| rsp_valid | output | 1 | Response strobe |
| rsp_lin | output | 32 | Linear address (0 on a fault) |
| rsp_fault | output | 1 | Translation fault |
| rsp_rpl | output | 2 | Requested privilege level from the selector |

## Verification
A table-register load and the acceptance of a request can fall in the same clock edge. The request must see the register contents from before that edge. The bench provokes this by raising `gtbl_ld` in the same cycle as `req_valid` while `req_ready` is high. It then sends the same selector again straight afterwards. The reference model computes the first expectation from its pre-load table values and the second from the new ones, so the two responses are judged against different fetch addresses and different limit outcomes.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    // Address and field widths shared by every module of the translator.
    localparam int LIN_W  = 32;                      // linear address / offset width
    localparam int SEL_W  = 16;                      // selector width
    localparam int RPL_W  = 2;                       // requested privilege field
    localparam int TI_W   = 1;                       // table-choice field
    localparam int ENT_SH = 3;                       // log2 of descriptor size in bytes
    localparam int DESC_W = 64;                      // descriptor width
    localparam int IDX_W  = SEL_W - RPL_W - TI_W;    // entry index width
    localparam int LIM_W  = IDX_W + ENT_SH;          // table length width

    // Descriptor base field placement.
    localparam int BLO_LSB = 16;
    localparam int BLO_W   = 24;
    localparam int BHI_LSB = 56;
    localparam int BHI_W   = LIN_W - BLO_W;

    typedef struct packed {
        logic [LIN_W-1:0] base;
        logic [LIM_W-1:0] limit;
    } tbl_reg_t;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             loc;
        logic [RPL_W-1:0] rpl;
    } sel_fld_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } xl_st_e;

    typedef struct packed {
        xl_st_e           st;
        logic [LIN_W-1:0] addr;
        logic [LIN_W-1:0] off;
        logic [RPL_W-1:0] rpl;
        logic             flt;
        logic [LIN_W-1:0] lin;
    } xl_ctx_t;

endpackage

// File: rtl/seg_tbl_reg.sv
module seg_tbl_reg
    import seg_xlate_pkg::*;
#(
    parameter logic [LIN_W-1:0] RST_BASE  = '0,
    parameter logic [LIM_W-1:0] RST_LIMIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [LIN_W-1:0] ld_base,
    input  logic [LIM_W-1:0] ld_limit,
    output tbl_reg_t         tbl_q
);

    tbl_reg_t tbl_d;

    always_comb begin
        tbl_d = tbl_q;
        if (ld) begin
            tbl_d.base  = ld_base;
            tbl_d.limit = ld_limit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q.base  <= RST_BASE;
            tbl_q.limit <= RST_LIMIT;
        end else begin
            tbl_q <= tbl_d;
        end
    end

endmodule

// File: rtl/seg_sel_check.sv
module seg_sel_check
    import seg_xlate_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  tbl_reg_t         gtbl,
    input  tbl_reg_t         ltbl,
    output logic [RPL_W-1:0] rpl,
    output logic [LIN_W-1:0] fetch_addr,
    output logic             null_flt,
    output logic             lim_flt
);

    localparam int PAD_W = LIN_W - IDX_W - ENT_SH;

    sel_fld_t         fld;
    tbl_reg_t         tbl;
    logic [LIM_W:0]   last_byte;

    always_comb begin
        fld = sel_fld_t'(sel);
        tbl = fld.loc ? ltbl : gtbl;

        // Highest byte of the addressed entry, one bit wider to hold any carry.
        last_byte = {1'b0, fld.idx, {ENT_SH{1'b0}}}
                  + {{(LIM_W + 1 - ENT_SH){1'b0}}, {ENT_SH{1'b1}}};

        lim_flt    = last_byte > {1'b0, tbl.limit};
        null_flt   = !fld.loc && (fld.idx == '0);
        fetch_addr = tbl.base + {{PAD_W{1'b0}}, fld.idx, {ENT_SH{1'b0}}};
        rpl        = fld.rpl;
    end

endmodule

// File: rtl/seg_desc_base.sv
module seg_desc_base
    import seg_xlate_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    output logic [LIN_W-1:0]  base
);

    // Type, access and limit fields are not needed for the base.
    logic desc_unused;

    always_comb begin
        base = {desc[BHI_LSB +: BHI_W], desc[BLO_LSB +: BLO_W]};
        desc_unused = ^{desc[BHI_LSB-1:BLO_LSB+BLO_W], desc[BLO_LSB-1:0]};
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [LIN_W-1:0]  req_off,
    input  logic              gtbl_ld,
    input  logic [LIN_W-1:0]  gtbl_base,
    input  logic [LIM_W-1:0]  gtbl_limit,
    input  logic              ltbl_ld,
    input  logic [LIN_W-1:0]  ltbl_base,
    input  logic [LIM_W-1:0]  ltbl_limit,
    output logic              mem_rd_en,
    output logic [LIN_W-1:0]  mem_addr,
    input  logic              mem_rd_valid,
    input  logic [DESC_W-1:0] mem_rd_data,
    output logic              rsp_valid,
    output logic [LIN_W-1:0]  rsp_lin,
    output logic              rsp_fault,
    output logic [RPL_W-1:0]  rsp_rpl
);

    localparam xl_ctx_t CTX_RST = '{
        st:   ST_IDLE,
        addr: '0,
        off:  '0,
        rpl:  '0,
        flt:  1'b0,
        lin:  '0
    };

    tbl_reg_t         gtbl_q;
    tbl_reg_t         ltbl_q;
    logic [RPL_W-1:0] sel_rpl;
    logic [LIN_W-1:0] sel_addr;
    logic             sel_null;
    logic             sel_lim;
    logic [LIN_W-1:0] desc_base;
    xl_ctx_t          ctx_d;
    xl_ctx_t          ctx_q;

    // Global table starts as a full-size table at address zero; local starts empty.
    seg_tbl_reg #(
        .RST_BASE  ('0),
        .RST_LIMIT ({LIM_W{1'b1}})
    ) u_gtbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (gtbl_ld),
        .ld_base  (gtbl_base),
        .ld_limit (gtbl_limit),
        .tbl_q    (gtbl_q)
    );

    seg_tbl_reg #(
        .RST_BASE  ('0),
        .RST_LIMIT ('0)
    ) u_ltbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (ltbl_ld),
        .ld_base  (ltbl_base),
        .ld_limit (ltbl_limit),
        .tbl_q    (ltbl_q)
    );

    seg_sel_check u_sel (
        .sel        (req_sel),
        .gtbl       (gtbl_q),
        .ltbl       (ltbl_q),
        .rpl        (sel_rpl),
        .fetch_addr (sel_addr),
        .null_flt   (sel_null),
        .lim_flt    (sel_lim)
    );

    seg_desc_base u_base (
        .desc (mem_rd_data),
        .base (desc_base)
    );

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctx_d.off  = req_off;
                    ctx_d.rpl  = sel_rpl;
                    ctx_d.addr = sel_addr;
                    if (sel_null || sel_lim) begin
                        ctx_d.flt = 1'b1;
                        ctx_d.lin = '0;
                        ctx_d.st  = ST_RESP;
                    end else begin
                        ctx_d.flt = 1'b0;
                        ctx_d.st  = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                ctx_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rd_valid) begin
                    ctx_d.lin = desc_base + ctx_q.off;
                    ctx_d.st  = ST_RESP;
                end
            end
            ST_RESP: begin
                ctx_d.st = ST_IDLE;
            end
            default: begin
                ctx_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= CTX_RST;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    always_comb begin
        req_ready = (ctx_q.st == ST_IDLE);
        mem_rd_en = (ctx_q.st == ST_ISSUE);
        mem_addr  = ctx_q.addr;
        rsp_valid = (ctx_q.st == ST_RESP);
        rsp_lin   = ctx_q.lin;
        rsp_fault = ctx_q.flt;
        rsp_rpl   = ctx_q.rpl;
    end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
    import seg_xlate_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             mem_rd_en,
    input logic             rsp_valid,
    input logic             rsp_fault,
    input logic [LIN_W-1:0] rsp_lin
);

    // R3: the read strobe never lasts longer than one cycle.
    assert_rd_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R3: a read is only issued while a request is in progress.
    assert_rd_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !req_ready);

    // R5: a fault never carries a linear address.
    assert_fault_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_lin == '0));

    // R8: acceptance closes the handshake for the following cycle.
    assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R8: a response lasts one cycle and reopens the request side.
    assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R8: no response is given while the block is idle.
    assert_rsp_not_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

endmodule

bind seg_xlate seg_xlate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .mem_rd_en (mem_rd_en),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_lin   (rsp_lin)
);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [15:0] req_sel;
    logic [31:0] req_off;
    logic        gtbl_ld;
    logic [31:0] gtbl_base;
    logic [15:0] gtbl_limit;
    logic        ltbl_ld;
    logic [31:0] ltbl_base;
    logic [15:0] ltbl_limit;
    logic        mem_rd_en;
    logic [31:0] mem_addr;
    logic        mem_rd_valid;
    logic [63:0] mem_rd_data;
    logic        rsp_valid;
    logic [31:0] rsp_lin;
    logic        rsp_fault;
    logic [1:0]  rsp_rpl;

    seg_xlate u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_sel      (req_sel),
        .req_off      (req_off),
        .gtbl_ld      (gtbl_ld),
        .gtbl_base    (gtbl_base),
        .gtbl_limit   (gtbl_limit),
        .ltbl_ld      (ltbl_ld),
        .ltbl_base    (ltbl_base),
        .ltbl_limit   (ltbl_limit),
        .mem_rd_en    (mem_rd_en),
        .mem_addr     (mem_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .rsp_valid    (rsp_valid),
        .rsp_lin      (rsp_lin),
        .rsp_fault    (rsp_fault),
        .rsp_rpl      (rsp_rpl)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int    vectors = 0;
    int    miscompares = 0;
    string tag = "reset";
    bit    finished = 1'b0;

    // Reference model state.
    logic [31:0] m_gbase = 32'h0;
    logic [15:0] m_glim  = 16'hFFFF;
    logic [31:0] m_lbase = 32'h0;
    logic [15:0] m_llim  = 16'h0;
    bit          busy = 1'b0;
    bit          issue_due = 1'b0;
    bit          rsp_due = 1'b0;
    bit          mem_pend = 1'b0;
    int          mem_cnt = 0;
    int          nreads = 0;
    logic [31:0] exp_addr;
    logic [31:0] exp_lin;
    logic        exp_flt;
    logic [1:0]  exp_rpl;
    logic [12:0] a_idx;
    logic        a_loc;
    logic [31:0] a_base;
    logic [15:0] a_lim;
    logic [63:0] a_desc;

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s [%s]: actual %h expected %h", what, tag, act, exp);
        end
    endtask

    function automatic logic [63:0] desc_of(input logic [31:0] a);
        return {a ^ 32'hA5C3_3C5A, ~a + 32'h1357_9BDF};
    endfunction

    // Cycle-by-cycle model, compared away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R8 req_ready", {63'b0, req_ready}, {63'b0, !busy});
            chk("R3/R5 mem_rd_en", {63'b0, mem_rd_en}, {63'b0, issue_due});
            if (issue_due && mem_rd_en)
                chk("R3 mem_addr", {32'b0, mem_addr}, {32'b0, exp_addr});
            chk("R8 rsp_valid", {63'b0, rsp_valid}, {63'b0, rsp_due});
            if (rsp_due && rsp_valid) begin
                chk("R4 rsp_lin", {32'b0, rsp_lin}, {32'b0, exp_lin});
                chk("R5/R6 rsp_fault", {63'b0, rsp_fault}, {63'b0, exp_flt});
                chk("R2 rsp_rpl", {62'b0, rsp_rpl}, {62'b0, exp_rpl});
            end

            if (rsp_due) begin
                rsp_due = 1'b0;
                busy = 1'b0;
            end
            if (mem_rd_valid) mem_rd_valid = 1'b0;
            if (mem_pend) begin
                mem_cnt--;
                if (mem_cnt == 0) begin
                    mem_pend = 1'b0;
                    mem_rd_valid = 1'b1;
                    mem_rd_data = desc_of(exp_addr);
                    rsp_due = 1'b1;
                end
            end
            if (issue_due) begin
                issue_due = 1'b0;
                mem_pend = 1'b1;
                mem_cnt = 1 + (nreads % 3);
                nreads++;
            end

            if (req_valid && req_ready) begin
                a_idx  = req_sel[15:3];
                a_loc  = req_sel[2];
                a_base = a_loc ? m_lbase : m_gbase;
                a_lim  = a_loc ? m_llim : m_glim;
                busy    = 1'b1;
                exp_rpl = req_sel[1:0];
                exp_flt = (!a_loc && a_idx == 13'd0) || ({a_idx, 3'b111} > a_lim);
                if (exp_flt) begin
                    exp_lin = 32'h0;
                    rsp_due = 1'b1;
                end else begin
                    exp_addr = a_base + {16'h0, a_idx, 3'b000};
                    a_desc   = desc_of(exp_addr);
                    exp_lin  = {a_desc[63:56], a_desc[39:16]} + req_off;
                    issue_due = 1'b1;
                end
            end
            if (gtbl_ld) begin
                m_gbase = gtbl_base;
                m_glim  = gtbl_limit;
            end
            if (ltbl_ld) begin
                m_lbase = ltbl_base;
                m_llim  = ltbl_limit;
            end
        end
    end

    task automatic send(input logic [15:0] s, input logic [31:0] o,
                        input bit gl = 1'b0, input logic [31:0] gb = 32'h0,
                        input logic [15:0] glim = 16'h0);
        do begin
            @(posedge clk);
            #1;
        end while (!req_ready);
        req_valid  = 1'b1;
        req_sel    = s;
        req_off    = o;
        gtbl_ld    = gl;
        gtbl_base  = gb;
        gtbl_limit = glim;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        gtbl_ld   = 1'b0;
    endtask

    task automatic load_gbl(input logic [31:0] b, input logic [15:0] l);
        @(posedge clk);
        #1;
        gtbl_ld = 1'b1; gtbl_base = b; gtbl_limit = l;
        @(posedge clk);
        #1;
        gtbl_ld = 1'b0;
    endtask

    task automatic load_loc(input logic [31:0] b, input logic [15:0] l);
        @(posedge clk);
        #1;
        ltbl_ld = 1'b1; ltbl_base = b; ltbl_limit = l;
        @(posedge clk);
        #1;
        ltbl_ld = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        miscompares++;
        $display("FAIL watchdog [%s]: actual hung expected done", tag);
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        int unsigned r;
        logic [12:0] ridx;
        req_valid = 0; req_sel = 0; req_off = 0;
        gtbl_ld = 0; gtbl_base = 0; gtbl_limit = 0;
        ltbl_ld = 0; ltbl_base = 0; ltbl_limit = 0;
        mem_rd_valid = 0; mem_rd_data = 0;
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1: idle outputs straight after reset.
        @(negedge clk);
        chk("R1 reset req_ready", {63'b0, req_ready}, 64'd1);
        chk("R1 reset mem_rd_en", {63'b0, mem_rd_en}, 64'd0);
        chk("R1 reset rsp_valid", {63'b0, rsp_valid}, 64'd0);

        // R9 and R1: entry 3 of the reset global table, privilege 0.
        tag = "R9 sel 0x18";
        send(16'h0018, 32'h0000_0100);
        // R1: reset global length reaches the last entry.
        tag = "R1 top entry";
        send(16'hFFFB, 32'h1234_5678);
        // R1: reset local table is empty, so local index 0 faults.
        tag = "R1 empty local";
        send(16'h0004, 32'h0000_0001);
        // R6: null selectors.
        tag = "R6 null";
        send(16'h0000, 32'hDEAD_BEEF);
        send(16'h0003, 32'h0000_0040);

        // R5: global limit boundary.
        load_gbl(32'h0001_0000, 16'h003F);
        tag = "R5 last in";
        send(16'h0039, 32'h0000_0010);
        tag = "R5 first out";
        send(16'h0040, 32'h0000_0010);

        // R6 and R5: local table index 0 is valid; boundary at 0x17.
        load_loc(32'h0020_0000, 16'h0017);
        tag = "R6 local idx0";
        send(16'h0004, 32'h0000_0200);
        tag = "R5 local last";
        send(16'h0016, 32'h0000_0300);
        tag = "R5 local out";
        send(16'h001E, 32'h0000_0300);

        // R4: base plus offset wraps.
        tag = "R4 wrap";
        send(16'h0008, 32'hFFFF_FFF0);

        // R7: load in the acceptance cycle; first request sees old table.
        tag = "R7 concurrent load";
        send(16'h0048, 32'h0000_0777, 1'b1, 32'h0030_0000, 16'h00FF);
        send(16'h0048, 32'h0000_0777);
        load_gbl(32'h0001_0000, 16'h003F);

        // R2, R3, R4, R5: mixed traffic.
        tag = "R2 mixed";
        r = 32'h1ACE_B00C;
        for (int i = 0; i < 40; i++) begin
            r = r * 32'd1103515245 + 32'd12345;
            ridx = 13'(r[27:16] % 12);
            send({ridx, r[2], r[5:4]}, r ^ 32'h5555_AAAA);
        end

        do begin
            @(posedge clk);
            #1;
        end while (!req_ready || busy);
        repeat (3) @(posedge clk);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule